// File: doc/BRIEF.md
# Serial Clock Generator with Prescaler and Interval Timer

This block derives the serial clock used by a serial-bus master sequencer from the system clock. The system clock first passes through a power-of-two prescaler selected by a 4-bit exponent. Two independent counters then time the active half and the idle half of the serial clock in prescaled clocks. The output clock sits at a programmable idle level, so it covers both clock polarities. Alongside the clock, the block gives single-cycle strobes that mark the leading edge (leaving idle) and the trailing edge (returning to idle), for the data shifter to use.

The same two 8-bit duration settings can also be used as one 16-bit reload value for a free-running interval timer. The active-half setting forms the upper byte and the idle-half setting forms the lower byte. In this mode the serial clock stays idle and a single-cycle tick is produced each time the count reloads.

Top module: `sclk_gen`

## Requirements
- R1: After reset, `sclk_o` equals `cpol_i`, and `lead_o`, `trail_o` and `tick_o` are 0.
- R2: While `run_i` is 0, `sclk_o` stays at the idle level `cpol_i` and no edge strobe is produced.
- R3: The prescaled clock period is 2^s system clocks, where s is `scale_i`, and any `scale_i` value above 8 acts as 8 (divide by 256).
- R4: After `run_i` rises, the first leading edge comes `lo_set_i`×2^s system clocks later (one full idle half).
- R5: The active half lasts `hi_set_i`×2^s system clocks, and each later idle half lasts `lo_set_i`×2^s system clocks.
- R6: A `hi_set_i` or `lo_set_i` value of 0 acts as 1.
- R7: A leading edge drives `sclk_o` to the inverse of `cpol_i`, and a trailing edge drives it back to `cpol_i`, so with `cpol_i`=1 the clock idles high.
- R8: `lead_o` and `trail_o` are single-cycle pulses that are never high together, and each is high in the cycle where `sclk_o` takes its new level.
- R9: With `timer_mode_i`=1, `tick_o` pulses once every N×2^s system clocks, where N = {`hi_set_i`,`lo_set_i`} (upper byte from `hi_set_i`) and N=0 acts as 1. The first tick comes N×2^s clocks after the mode is entered.
- R10: With `timer_mode_i`=1, the serial clock stays idle and no edge strobe is produced, even when `run_i` is 1.
- R11: When `run_i` falls, `sclk_o` returns to idle on the next clock. A later run request restarts with a full idle half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run request for the serial clock |
| timer_mode_i | input | 1 | Selects the free-running interval timer |
| cpol_i | input | 1 | Idle level of the serial clock |
| scale_i | input | 4 | Prescaler exponent (divide by 2^scale, capped at 8) |
| hi_set_i | input | 8 | Active-half length; timer reload upper byte |
| lo_set_i | input | 8 | Idle-half length; timer reload lower byte |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | Leading-edge strobe |
| trail_o | output | 1 | Trailing-edge strobe |
| tick_o | output | 1 | Timer reload tick |

## Verification
The clock path is run with several settings. Equal settings of 1 at no prescale give the fastest toggle. Unequal active and idle lengths show whether the two counters are swapped. Zero settings check the treat-as-one rule, an exponent above 8 checks the cap, and an inverted polarity shows which level the clock idles at. For each setting the bench measures the delay to the first edge and both half lengths in system clocks, so an off-by-one in the prescaler stands apart from one in the phase counters. The timer is tried with a reload taken only from the lower byte, with one taken from the upper byte, and with a zero reload. This shows the byte order and the zero rule, and it also shows that an active run request leaves the clock silent in timer mode.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

   typedef enum logic {
      PH_IDLE   = 1'b0,
      PH_ACTIVE = 1'b1
   } sclk_phase_e;

   function automatic logic [15:0] at_least_one(input logic [15:0] v);
      return (v == 16'd0) ? 16'd1 : v;
   endfunction

endpackage

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
   parameter int SCALE_W   = 4,
   parameter int MAX_SCALE = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active_i,
   input  logic [SCALE_W-1:0] scale_i,
   output logic               tick_o
);
   localparam int PRE_W = (MAX_SCALE > 0) ? MAX_SCALE : 1;

   if (SCALE_W < 1) begin : g_bad_w
      $error("sclk_prescaler: SCALE_W must be at least 1");
   end
   if (MAX_SCALE >= (1 << SCALE_W)) begin : g_bad_max
      $error("sclk_prescaler: MAX_SCALE does not fit in SCALE_W");
   end

   if (MAX_SCALE == 0) begin : g_direct
      assign tick_o = active_i;
   end else begin : g_count
      logic [SCALE_W-1:0] s_eff;
      logic [PRE_W-1:0]   lim;
      logic [PRE_W-1:0]   cnt_q;

      always_comb begin
         s_eff = (scale_i > SCALE_W'(MAX_SCALE)) ? SCALE_W'(MAX_SCALE) : scale_i;
         for (int i = 0; i < PRE_W; i++) begin
            lim[i] = (i < int'(s_eff));
         end
      end

      assign tick_o = active_i && (cnt_q >= lim);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (!active_i || tick_o) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      // R3: every prescaled tick restarts the count from zero
      a_r3_restart_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
         tick_o |=> (cnt_q == '0));
   end

endmodule

// File: rtl/sclk_phase_ctr.sv
module sclk_phase_ctr
   import sclk_pkg::*;
#(
   parameter int SET_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [SET_W-1:0] hi_set_i,
   input  logic [SET_W-1:0] lo_set_i,
   output logic             active_o,
   output logic             lead_o,
   output logic             trail_o
);
   if (SET_W < 1 || SET_W > 16) begin : g_bad_w
      $error("sclk_phase_ctr: SET_W must be 1 to 16");
   end

   sclk_phase_e      phase_q;
   logic [SET_W-1:0] cnt_q;
   logic [SET_W-1:0] len_m1;
   logic             edge_now;
   logic             lead_q, trail_q;

   always_comb begin
      logic [15:0] len;
      len = (phase_q == PH_ACTIVE) ? at_least_one(16'(hi_set_i))
                                   : at_least_one(16'(lo_set_i));
      len_m1 = SET_W'(len - 16'd1);
   end

   assign edge_now = run_i && tick_i && (cnt_q >= len_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
      end else if (!run_i) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
      end else begin
         lead_q  <= edge_now && (phase_q == PH_IDLE);
         trail_q <= edge_now && (phase_q == PH_ACTIVE);
         if (edge_now) begin
            cnt_q   <= '0;
            phase_q <= (phase_q == PH_IDLE) ? PH_ACTIVE : PH_IDLE;
         end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign active_o = (phase_q == PH_ACTIVE);
   assign lead_o   = lead_q;
   assign trail_o  = trail_q;

   // R8: strobes mark the cycle where the phase has just turned
   a_r8_lead_enters_active: assert property (@(posedge clk) disable iff (!rst_n)
      lead_o |-> (phase_q == PH_ACTIVE));
   a_r8_trail_enters_idle: assert property (@(posedge clk) disable iff (!rst_n)
      trail_o |-> (phase_q == PH_IDLE));
   a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_o && trail_o));
   // R5: the phase only turns on a prescaled tick
   a_r5_turn_on_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !tick_i) |=> $stable(phase_q));
   // R11: dropping the run request parks the clock at idle
   a_r11_park_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (phase_q == PH_IDLE && !lead_o && !trail_o));

endmodule

// File: rtl/sclk_interval_timer.sv
module sclk_interval_timer
   import sclk_pkg::*;
#(
   parameter int SET_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic [SET_W-1:0] hi_set_i,
   input  logic [SET_W-1:0] lo_set_i,
   output logic             tick_o
);
   localparam int TMR_W = 2 * SET_W;

   if (TMR_W > 16) begin : g_bad_w
      $error("sclk_interval_timer: reload wider than 16 bits");
   end

   logic [TMR_W-1:0] per_m1;
   logic [TMR_W-1:0] cnt_q;
   logic             tick_q;

   assign per_m1 = TMR_W'(at_least_one(16'({hi_set_i, lo_set_i})) - 16'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else if (!en_i) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else if (tick_i) begin
         tick_q <= (cnt_q >= per_m1);
         cnt_q  <= (cnt_q >= per_m1) ? '0 : cnt_q + 1'b1;
      end else begin
         tick_q <= 1'b0;
      end
   end

   assign tick_o = tick_q;

   // R9: a reload tick follows a prescaled tick and leaves the count at zero
   a_r9_tick_from_prescale: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> $past(tick_i));
   a_r9_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> (cnt_q == '0));
   a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !tick_o);

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
   parameter int SET_W     = 8,
   parameter int SCALE_W   = 4,
   parameter int MAX_SCALE = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic               timer_mode_i,
   input  logic               cpol_i,
   input  logic [SCALE_W-1:0] scale_i,
   input  logic [SET_W-1:0]   hi_set_i,
   input  logic [SET_W-1:0]   lo_set_i,
   output logic               sclk_o,
   output logic               lead_o,
   output logic               trail_o,
   output logic               tick_o
);
   logic clk_run;
   logic pre_active;
   logic pre_tick;
   logic phase_active;

   assign clk_run    = run_i && !timer_mode_i;
   assign pre_active = clk_run || timer_mode_i;

   sclk_prescaler #(.SCALE_W(SCALE_W), .MAX_SCALE(MAX_SCALE)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (pre_active),
      .scale_i  (scale_i),
      .tick_o   (pre_tick)
   );

   sclk_phase_ctr #(.SET_W(SET_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (clk_run),
      .tick_i   (pre_tick),
      .hi_set_i (hi_set_i),
      .lo_set_i (lo_set_i),
      .active_o (phase_active),
      .lead_o   (lead_o),
      .trail_o  (trail_o)
   );

   sclk_interval_timer #(.SET_W(SET_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (timer_mode_i),
      .tick_i   (pre_tick),
      .hi_set_i (hi_set_i),
      .lo_set_i (lo_set_i),
      .tick_o   (tick_o)
   );

   assign sclk_o = phase_active ^ cpol_i;

   // R10: timer mode keeps the serial clock silent
   a_r10_timer_silences_clock: assert property (@(posedge clk) disable iff (!rst_n)
      timer_mode_i |=> (!lead_o && !trail_o));
   // R2: without a run request no edge strobe appears
   a_r2_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (!lead_o && !trail_o));
   // R7: the clock sits at the idle level whenever a trailing edge is flagged
   a_r7_trail_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
      trail_o |-> (sclk_o == cpol_i));

endmodule

// File: tb/sclk_gen_test.sv
`timescale 1ns/1ps
module sclk_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_i = 1'b0;
   logic       timer_mode_i = 1'b0;
   logic       cpol_i = 1'b0;
   logic [3:0] scale_i = '0;
   logic [7:0] hi_set_i = '0;
   logic [7:0] lo_set_i = '0;
   logic       sclk_o, lead_o, trail_o, tick_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sclk_gen uut (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .timer_mode_i(timer_mode_i),
      .cpol_i(cpol_i), .scale_i(scale_i), .hi_set_i(hi_set_i), .lo_set_i(lo_set_i),
      .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o), .tick_o(tick_o)
   );

   // rows: scale, hi, lo, cpol, expected first lead, active half, idle half (clocks)
   localparam int NROW = 6;
   localparam int T_SCALE [NROW] = '{0, 0, 2, 1, 12, 3};
   localparam int T_HI    [NROW] = '{1, 3, 2, 0, 1, 4};
   localparam int T_LO    [NROW] = '{1, 5, 1, 0, 2, 3};
   localparam int T_POL   [NROW] = '{0, 1, 0, 1, 0, 1};
   localparam int T_FIRST [NROW] = '{1, 5, 4, 2, 512, 24};
   localparam int T_HIGH  [NROW] = '{1, 3, 8, 2, 256, 32};
   localparam int T_LOW   [NROW] = '{1, 5, 4, 2, 512, 24};

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wait_for(input bit want_lead, output int n, output int stray);
      n = 0;
      stray = 0;
      do begin
         step();
         n++;
         if (want_lead ? trail_o : lead_o) stray++;
      end while (!(want_lead ? lead_o : trail_o) && n < 3000);
   endtask

   task automatic measure_tick(output int n);
      n = 0;
      do begin
         step();
         n++;
      end while (!tick_o && n < 3000);
   endtask

   initial begin
      int n, stray, ticks, strobes, idle_bad;
      @(negedge clk);
      // R1: reset state
      chk("R1 sclk at reset", int'(sclk_o), 0);
      chk("R1 strobes at reset", int'(lead_o | trail_o | tick_o), 0);
      step();
      rst_n = 1'b1;
      step();

      for (int r = 0; r < NROW; r++) begin
         run_i = 1'b0;
         timer_mode_i = 1'b0;
         scale_i = 4'(T_SCALE[r]);
         hi_set_i = 8'(T_HI[r]);
         lo_set_i = 8'(T_LO[r]);
         cpol_i = T_POL[r][0];
         idle_bad = 0;
         for (int k = 0; k < 4; k++) begin
            step();
            if (sclk_o != cpol_i || lead_o || trail_o) idle_bad++;
         end
         chk("R2 idle level without run", idle_bad, 0);
         run_i = 1'b1;
         wait_for(1'b1, n, stray);
         chk("R4 R3 R6 first leading edge delay", n, T_FIRST[r]);
         chk("R7 level after leading edge", int'(sclk_o), int'(!cpol_i));
         wait_for(1'b0, n, stray);
         chk("R5 R3 R6 active half length", n, T_HIGH[r]);
         chk("R8 lead single-cycle, never with trail", stray, 0);
         chk("R7 level after trailing edge", int'(sclk_o), int'(cpol_i));
         wait_for(1'b1, n, stray);
         chk("R5 idle half length", n, T_LOW[r]);
         chk("R8 trail single-cycle", stray, 0);
      end

      // R11: stop mid active half, then restart
      run_i = 1'b0;
      scale_i = 4'd0; hi_set_i = 8'd5; lo_set_i = 8'd3; cpol_i = 1'b1;
      step(); step();
      run_i = 1'b1;
      wait_for(1'b1, n, stray);
      step();
      run_i = 1'b0;
      step();
      chk("R11 idle next cycle after stop", int'(sclk_o), 1);
      chk("R11 no strobe on stop", int'(lead_o | trail_o), 0);
      run_i = 1'b1;
      wait_for(1'b1, n, stray);
      chk("R11 restart with full idle half", n, 3);
      run_i = 1'b0;
      step(); step();

      // R9: reload from lower byte, scale 1 -> 3*2 clocks
      cpol_i = 1'b0; scale_i = 4'd1; hi_set_i = 8'd0; lo_set_i = 8'd3;
      timer_mode_i = 1'b1;
      measure_tick(n);
      chk("R9 first tick, lower-byte reload", n, 6);
      measure_tick(n);
      chk("R9 tick period, lower-byte reload", n, 6);
      timer_mode_i = 1'b0;
      step(); step();

      // R9: upper byte is the high part: {1,0} = 256 at scale 0
      scale_i = 4'd0; hi_set_i = 8'd1; lo_set_i = 8'd0;
      timer_mode_i = 1'b1;
      measure_tick(n);
      chk("R9 upper-byte reload period", n, 256);
      timer_mode_i = 1'b0;
      step(); step();

      // R9: zero reload acts as 1 -> tick every prescaled clock (scale 2 -> 4)
      scale_i = 4'd2; hi_set_i = 8'd0; lo_set_i = 8'd0;
      timer_mode_i = 1'b1;
      measure_tick(n);
      chk("R9 zero reload first tick", n, 4);
      measure_tick(n);
      chk("R9 zero reload period", n, 4);
      timer_mode_i = 1'b0;
      step(); step();

      // R10: timer mode with run request keeps clock silent; reload 2, scale 0
      scale_i = 4'd0; hi_set_i = 8'd0; lo_set_i = 8'd2; cpol_i = 1'b1;
      timer_mode_i = 1'b1; run_i = 1'b1;
      ticks = 0; strobes = 0; idle_bad = 0;
      for (int k = 0; k < 20; k++) begin
         step();
         if (tick_o) ticks++;
         if (lead_o || trail_o) strobes++;
         if (sclk_o != 1'b1) idle_bad++;
      end
      chk("R10 no strobes in timer mode", strobes, 0);
      chk("R10 clock idle in timer mode", idle_bad, 0);
      chk("R9 tick count over 20 clocks", ticks, 10);
      timer_mode_i = 1'b0; run_i = 1'b0;
      step();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule